// File: doc/BRIEF.md
# Multiplexed Bank Byte Capture

This block recovers the upper address byte of a processor that puts that byte on its data pins while its phase-2 clock is low. A fast system clock runs the block. On each edge of that clock the block registers the phase-2 level, the data pins and a force-zero control, so no select line downstream is driven straight from a pin.

While the registered phase-2 is low, the block shows the latest data sample as the bank and also copies it into a hold register. When the registered phase-2 goes high, the output switches to the hold register. It then stays frozen until phase-2 falls again. A data-bus turnaround after the rise therefore cannot reach the decoder. A one-cycle strobe marks the edge at which the bank freezes. A force-zero input pins the bank to zero, and an active-high asynchronous reset clears everything.

Address decode logic reads the bank output and acts on the strobe.

Top module: `bank_capture`

## Requirements
- R1: While `rst` is high, `bank` reads 0 and `bank_valid` reads 0 at once, without waiting for a clock edge.
- R2: `phase_hi`, `din` and `force_zero` each pass through `IN_STAGES` flip-flop stages (default 1). With registered phase low and registered force low, `bank` equals the `din` value sampled `IN_STAGES` rising edges earlier.
- R3: The hold register reloads on every rising edge at which registered phase is low. The frozen value therefore comes from the last low cycle and never from an earlier one.
- R4: With registered phase low, a registered `force_zero` of 1 makes `bank` read 0. The zero is also what the hold register loads.
- R5: With registered phase high, `bank` does not change. Changes on `din` or `force_zero` in that time have no effect on it.
- R6: `bank_valid` is 1 for exactly one cycle: the first cycle in which registered phase is high. It is 0 at all other times.
- R7: In the cycle in which registered phase goes high, `bank` keeps the value it showed in the cycle before, so the switch from live sample to hold register leaves no step.
- R8: If `force_zero` is first sampled at the same edge as the phase-2 rise, the frozen bank is not zeroed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| phase_hi | input | 1 | Processor phase-2 clock level |
| din | input | BANK_W | Processor data pins carrying the bank byte in the low phase |
| force_zero | input | 1 | Forces the captured bank to all zeros |
| bank | output | BANK_W | Bank value for address decoding |
| bank_valid | output | 1 | One-cycle pulse when the bank freezes |

## Verification
Two functions can meet at the phase-2 rise: the force-zero load and the freeze with its strobe. The bench sweeps every byte value. For some values, force is raised only in the cycle before the rise; in that case the frozen bank must read zero. For other values, force is raised exactly at the rise edge; in that case the frozen bank must keep the byte. In each high phase the bench then drives a turnaround value with force set, and the expected bank is computed from the byte and the force timing alone.

// File: rtl/bank_capture_pkg.sv
package bank_capture_pkg;

   parameter int unsigned BANK_W_DEF   = 8;
   parameter int unsigned IN_STAGES_DEF = 1;

   function automatic logic [BANK_W_DEF-1:0] zero_or(input logic clr,
                                                      input logic [BANK_W_DEF-1:0] v);
      return clr ? '0 : v;
   endfunction

endpackage

// File: rtl/bank_sync_pipe.sv
module bank_sync_pipe #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int unsigned LAST = STAGES - 1;

   logic [W-1:0] stg [STAGES];

   if (STAGES < 1) begin : g_bad_stages
      $error("bank_sync_pipe: STAGES must be at least 1");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or posedge rst) begin
            if (rst) stg[0] <= '0;
            else     stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge rst) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[LAST];
endmodule

// File: rtl/bank_freeze_mux.sv
module bank_freeze_mux #(
   parameter int unsigned BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ph_s,
   input  logic              f_s,
   input  logic [BANK_W-1:0] d_s,
   output logic [BANK_W-1:0] bank
);
   logic [BANK_W-1:0] live;
   logic [BANK_W-1:0] held;

   assign live = f_s ? '0 : d_s;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)        held <= '0;
      else if (!ph_s) held <= live;
   end

   assign bank = ph_s ? held : live;
endmodule

// File: rtl/bank_rise_pulse.sv
module bank_rise_pulse (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic pulse
);
   logic lvl_d;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) lvl_d <= 1'b0;
      else     lvl_d <= lvl;
   end

   assign pulse = lvl & ~lvl_d;
endmodule

// File: rtl/bank_capture.sv
module bank_capture #(
   parameter int unsigned BANK_W    = bank_capture_pkg::BANK_W_DEF,
   parameter int unsigned IN_STAGES = bank_capture_pkg::IN_STAGES_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              phase_hi,
   input  logic [BANK_W-1:0] din,
   input  logic              force_zero,
   output logic [BANK_W-1:0] bank,
   output logic              bank_valid
);
   localparam int unsigned PIPE_W = BANK_W + 2;

   if (BANK_W < 1) begin : g_bad_width
      $error("bank_capture: BANK_W must be at least 1");
   end
   if (IN_STAGES < 1) begin : g_bad_depth
      $error("bank_capture: IN_STAGES must be at least 1");
   end

   logic [PIPE_W-1:0] pipe_in;
   logic [PIPE_W-1:0] pipe_out;
   logic              ph_s;
   logic              f_s;
   logic [BANK_W-1:0] d_s;

   assign pipe_in = {phase_hi, force_zero, din};

   bank_sync_pipe #(.W(PIPE_W), .STAGES(IN_STAGES)) u_pipe (
      .clk (clk),
      .rst (rst),
      .d   (pipe_in),
      .q   (pipe_out)
   );

   assign ph_s = pipe_out[PIPE_W-1];
   assign f_s  = pipe_out[PIPE_W-2];
   assign d_s  = pipe_out[BANK_W-1:0];

   bank_freeze_mux #(.BANK_W(BANK_W)) u_mux (
      .clk  (clk),
      .rst  (rst),
      .ph_s (ph_s),
      .f_s  (f_s),
      .d_s  (d_s),
      .bank (bank)
   );

   bank_rise_pulse u_rise (
      .clk   (clk),
      .rst   (rst),
      .lvl   (ph_s),
      .pulse (bank_valid)
   );
endmodule

// File: rtl/bank_capture_chk.sv
module bank_capture_chk #(
   parameter int unsigned BANK_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              ph_s,
   input logic              f_s,
   input logic [BANK_W-1:0] d_s,
   input logic [BANK_W-1:0] bank,
   input logic              bank_valid
);
   AST_RESET_CLEAR: assert property (@(posedge clk) rst |-> (bank == '0 && !bank_valid)); // R1
   AST_LIVE_FOLLOW: assert property (@(posedge clk) disable iff (rst) (!ph_s && !f_s) |-> bank == d_s); // R2
   AST_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst) (!ph_s && f_s) |-> bank == '0); // R4
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) (ph_s && $past(ph_s)) |-> $stable(bank)); // R5
   AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst) $rose(ph_s) |-> bank_valid); // R6
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) bank_valid |=> !bank_valid); // R6
   AST_STROBE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst) bank_valid |-> ph_s); // R6
   AST_RISE_NO_STEP: assert property (@(posedge clk) disable iff (rst) $rose(ph_s) |-> bank == $past(bank)); // R7
endmodule

bind bank_capture bank_capture_chk #(.BANK_W(BANK_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ph_s       (ph_s),
   .f_s        (f_s),
   .d_s        (d_s),
   .bank       (bank),
   .bank_valid (bank_valid)
);

// File: tb/bank_capture_test.sv
module bank_capture_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       phase_hi = 1'b0;
   logic [7:0] din = 8'h00;
   logic       force_zero = 1'b0;
   logic [7:0] bank;
   logic       bank_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bank_capture uut (
      .clk        (clk),
      .rst        (rst),
      .phase_hi   (phase_hi),
      .din        (din),
      .force_zero (force_zero),
      .bank       (bank),
      .bank_valid (bank_valid)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
      end
   endtask

   // drive at a falling edge, return at the next falling edge (one rising edge later)
   task automatic cyc(input logic p, input logic [7:0] d, input logic f);
      phase_hi   = p;
      din        = d;
      force_zero = f;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      din = 8'hA5;
      phase_hi = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset bank", bank, 8'h00);
      chk("R1 reset valid", {7'd0, bank_valid}, 8'h00);
      rst = 1'b0;
      cyc(0, 8'h00, 0);

      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         logic       fl;
         logic       fr;
         logic [7:0] exp;
         b   = 8'(v);
         fl  = (v % 5) == 0;
         fr  = (v % 3) == 0;
         exp = fl ? 8'h00 : b;
         cyc(0, b ^ 8'h5A, 0);
         chk("R2 live early", bank, b ^ 8'h5A);
         chk("R6 no strobe low", {7'd0, bank_valid}, 8'h00);
         cyc(0, b, fl);
         chk(fl ? "R4 force live" : "R2 live", bank, exp);
         cyc(1, b, fr);
         chk(fr ? "R8 force at rise ignored" : "R7 no step at rise", bank, exp);
         chk("R3 last low value held", bank, exp);
         chk("R6 strobe at rise", {7'd0, bank_valid}, 8'h01);
         cyc(1, ~b, 1);
         chk("R5 turnaround ignored", bank, exp);
         chk("R6 strobe single", {7'd0, bank_valid}, 8'h00);
         cyc(1, b + 8'd1, 0);
         chk("R5 hold stable", bank, exp);
      end

      cyc(0, 8'h3C, 0);
      cyc(1, 8'h3C, 0);
      chk("R7 before reset", bank, 8'h3C);
      #2 rst = 1'b1;
      #1;
      chk("R1 async bank", bank, 8'h00);
      chk("R1 async valid", {7'd0, bank_valid}, 8'h00);
      @(negedge clk);
      rst = 1'b0;
      cyc(0, 8'hC3, 0);
      chk("R2 after reset", bank, 8'hC3);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule